// File: doc/BRIEF.md
# Software Style Configuration Register

This block is the control-register slice of a bus-master network controller. It holds an 8-bit software-style code. Two mode flags are decoded from it. The first is a 32-bit-structure flag, which selects whether descriptors and the initialization block use 16-bit or 32-bit layouts. The second is a feature-enable flag, which decides whether a few bits of a companion feature register reach their outputs.

The same code also affects the bus-master datapath. It decides whether the top byte of every master address comes from a stored high address byte or from the pointer itself. It also decides whether transmit-descriptor bit 29 requests or suppresses the frame check sequence.

Software reaches four registers through a simple select/read/write port. The style and identification registers are open only while the controller reports STOP. A hard reset and a soft reset both restore the default style, but they treat the derived structure flag differently.

Top module: `swstyle_top`

## Requirements
- R1: A valid style code written to the style register (select 0, bits 7:0) sets the flags from the next clock edge: code 00h gives featEn=1 and struct32=0, code 01h gives featEn=0 and struct32=1, and code 02h gives featEn=1 and struct32=1.
- R2: A reserved style code (any value other than 00h, 01h or 02h) clears both featEn and struct32 and sets styleBad. styleBad stays set through later valid writes and soft resets, and only a hard reset clears it.
- R3: While stopIn is 0, writes to the style register are ignored, and reads of the style register (select 0) and the identification register (select 1) return 0.
- R4: A hard reset clears the style code to 00h, struct32 to 0, styleBad to 0, the companion register to 0 and the address high byte to 0, and sets featEn to 1.
- R5: A soft reset clears the style code to 00h and sets featEn to 1. It leaves struct32, styleBad, the companion register and the address high byte unchanged.
- R6: A style read returns the code in bits 7:0, struct32 in bit 8 and styleBad in bit 15, with all other bits 0. Writes to bits 15:8 of the style register have no effect.
- R7: masterAddr equals {address high byte, ptrIn[23:0]} while struct32 is 0, and equals ptrIn while struct32 is 1.
- R8: The companion register (select 2) always reads back what was written. featOut equals the written value, except that while featEn is 0 the output bits 9:8, 5:4 and 1:0 are 0.
- R9: appendFcs equals the inverse of txBit29 when featEn is 0 and struct32 is 1. In every other combination it equals txBit29.
- R10: The identification register (select 1) reads 0105h while stopIn is 1 and ignores writes.
- R11: The address high byte register (select 3) can be written at any time and reads back in bits 7:0, with bits 15:8 reading 0. rdData is 0 whenever rdEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRst | input | 1 | Synchronous hard reset, active high |
| softRst | input | 1 | Synchronous soft reset, active high |
| stopIn | input | 1 | Controller STOP status; opens the style and identification registers |
| regSel | input | 2 | Register select: 0 style, 1 identification, 2 companion, 3 address high byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from the selected register |
| ptrIn | input | 32 | Pointer taken from the software structures |
| txBit29 | input | 1 | Bit 29 of the current transmit descriptor |
| masterAddr | output | 32 | Formed bus-master address |
| struct32 | output | 1 | 32-bit-structure flag |
| featEn | output | 1 | Feature-enable flag |
| styleBad | output | 1 | Sticky reserved-style indication |
| featOut | output | 16 | Effective companion register bits after masking |
| appendFcs | output | 1 | Final decision to append the frame check sequence |

## Verification
A vector table writes each valid style code, two reserved codes, and a repeat of a valid code after a reserved one. For each entry the bench checks both flags, the style read-back layout, the master address for a pointer whose top byte differs from the stored high byte, and the FCS decision for both values of descriptor bit 29. Together these tell the three valid codes apart from one another and from reserved values, and they show that the invalid flag is sticky. Directed tests then write with STOP low and with STOP high, issue a soft reset after a 32-bit style to show that struct32 is kept while featEn returns to 1, write the identification register, and compare the masked companion bits against the raw read-back under style 01h and style 02h.

// File: rtl/swstyle_pkg.sv
package swstyle_pkg;

  localparam int DATA_W = 16;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] STYLE_LEGACY = 8'h00;
  localparam logic [CODE_W-1:0] STYLE_ALT32  = 8'h01;
  localparam logic [CODE_W-1:0] STYLE_NATIVE = 8'h02;

  localparam logic [DATA_W-1:0] ID_VALUE  = 16'h0105;
  localparam logic [DATA_W-1:0] FEAT_MASK = 16'h0333;

  typedef enum logic [1:0] {
    SEL_STYLE = 2'd0,
    SEL_ID    = 2'd1,
    SEL_FEAT  = 2'd2,
    SEL_IADR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrStyle;
    logic wrFeat;
    logic wrIadr;
    logic rdStyle;
    logic rdId;
    logic rdFeat;
    logic rdIadr;
  } strobes_t;

  typedef struct packed {
    logic valid;
    logic feat;
    logic wide;
  } styleDec_t;

  function automatic styleDec_t decodeStyle(input logic [CODE_W-1:0] code);
    styleDec_t d;
    case (code)
      STYLE_LEGACY: d = '{valid: 1'b1, feat: 1'b1, wide: 1'b0};
      STYLE_ALT32:  d = '{valid: 1'b1, feat: 1'b0, wide: 1'b1};
      STYLE_NATIVE: d = '{valid: 1'b1, feat: 1'b1, wide: 1'b1};
      default:      d = '{valid: 1'b0, feat: 1'b0, wide: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/swstyle_ctrl.sv
module swstyle_ctrl
  import swstyle_pkg::*;
(
  input  logic       clk,
  input  logic       hardRst,
  input  logic       stopIn,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  output strobes_t   strb
);

  regSel_e sel;
  assign sel = regSel_e'(regSel);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (sel)
        SEL_STYLE: strb.wrStyle = stopIn;
        SEL_FEAT:  strb.wrFeat  = 1'b1;
        SEL_IADR:  strb.wrIadr  = 1'b1;
        default:   ;
      endcase
    end
    if (rdEn) begin
      unique case (sel)
        SEL_STYLE: strb.rdStyle = stopIn;
        SEL_ID:    strb.rdId    = stopIn;
        SEL_FEAT:  strb.rdFeat  = 1'b1;
        SEL_IADR:  strb.rdIadr  = 1'b1;
      endcase
    end
  end

  // R3
  stop_gate_chk: assert property (@(posedge clk) disable iff (hardRst)
    !stopIn |-> !(strb.wrStyle || strb.rdStyle || strb.rdId));

  // R11
  rd_onehot_chk: assert property (@(posedge clk) disable iff (hardRst)
    $onehot0({strb.rdStyle, strb.rdId, strb.rdFeat, strb.rdIadr}));

endmodule

// File: rtl/swstyle_dp.sv
module swstyle_dp
  import swstyle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOW_W  = 24,
  localparam int HI_W  = ADDR_W - LOW_W
)(
  input  logic              clk,
  input  logic              hardRst,
  input  logic              softRst,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic              txBit29,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] masterAddr,
  output logic              struct32,
  output logic              featEn,
  output logic              styleBad,
  output logic [DATA_W-1:0] featOut,
  output logic              appendFcs
);

  logic [CODE_W-1:0] styleCode;
  logic [DATA_W-1:0] featReg;
  logic [HI_W-1:0]   iadrHi;
  styleDec_t         dec;

  assign dec = decodeStyle(wrData[CODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (hardRst) begin
      styleCode <= STYLE_LEGACY;
      struct32  <= 1'b0;
      featEn    <= 1'b1;
      styleBad  <= 1'b0;
    end else if (softRst) begin
      styleCode <= STYLE_LEGACY;
      featEn    <= 1'b1;
    end else if (strb.wrStyle) begin
      styleCode <= wrData[CODE_W-1:0];
      struct32  <= dec.wide;
      featEn    <= dec.feat;
      if (!dec.valid) styleBad <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (hardRst) begin
      featReg <= '0;
      iadrHi  <= '0;
    end else begin
      if (strb.wrFeat) featReg <= wrData;
      if (strb.wrIadr) iadrHi  <= wrData[HI_W-1:0];
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (FEAT_MASK[i]) begin : g_gated
      assign featOut[i] = featReg[i] & featEn;
    end else begin : g_pass
      assign featOut[i] = featReg[i];
    end
  end

  assign masterAddr = struct32 ? ptrIn : {iadrHi, ptrIn[LOW_W-1:0]};

  logic fcsInverted;
  assign fcsInverted = struct32 && !featEn;
  assign appendFcs   = fcsInverted ? !txBit29 : txBit29;

  always_comb begin
    rdData = '0;
    if (strb.rdStyle) begin
      rdData[CODE_W-1:0] = styleCode;
      rdData[8]          = struct32;
      rdData[15]         = styleBad;
    end else if (strb.rdId) begin
      rdData = ID_VALUE;
    end else if (strb.rdFeat) begin
      rdData = featReg;
    end else if (strb.rdIadr) begin
      rdData[HI_W-1:0] = iadrHi;
    end
  end

  // R1
  alt_style_chk: assert property (@(posedge clk) disable iff (hardRst)
    (strb.wrStyle && !softRst && wrData[CODE_W-1:0] == STYLE_ALT32) |=> (struct32 && !featEn));

  // R2
  bad_sticky_chk: assert property (@(posedge clk) disable iff (hardRst)
    styleBad |=> styleBad);

  // R5
  soft_keep_chk: assert property (@(posedge clk) disable iff (hardRst)
    softRst |=> ($stable(struct32) && featEn && styleCode == STYLE_LEGACY));

  // R8
  feat_mask_chk: assert property (@(posedge clk) disable iff (hardRst)
    !featEn |-> ((featOut & FEAT_MASK) == '0));

  // R7
  addr_low_chk: assert property (@(posedge clk) disable iff (hardRst)
    masterAddr[LOW_W-1:0] == ptrIn[LOW_W-1:0]);

endmodule

// File: rtl/swstyle_top.sv
module swstyle_top
  import swstyle_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOW_W  = 24
)(
  input  logic              clk,
  input  logic              hardRst,
  input  logic              softRst,
  input  logic              stopIn,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic              txBit29,
  output logic [ADDR_W-1:0] masterAddr,
  output logic              struct32,
  output logic              featEn,
  output logic              styleBad,
  output logic [15:0]       featOut,
  output logic              appendFcs
);

  strobes_t strb;

  swstyle_ctrl u_ctrl (
    .clk     (clk),
    .hardRst (hardRst),
    .stopIn  (stopIn),
    .regSel  (regSel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strb    (strb)
  );

  swstyle_dp #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_dp (
    .clk        (clk),
    .hardRst    (hardRst),
    .softRst    (softRst),
    .strb       (strb),
    .wrData     (wrData),
    .ptrIn      (ptrIn),
    .txBit29    (txBit29),
    .rdData     (rdData),
    .masterAddr (masterAddr),
    .struct32   (struct32),
    .featEn     (featEn),
    .styleBad   (styleBad),
    .featOut    (featOut),
    .appendFcs  (appendFcs)
  );

endmodule

// File: tb/swstyle_top_tb.sv
module swstyle_top_tb;

  logic        clk = 1'b0;
  logic        hardRst, softRst, stopIn, wrEn, rdEn, txBit29;
  logic [1:0]  regSel;
  logic [15:0] wrData, rdData, featOut;
  logic [31:0] ptrIn, masterAddr;
  logic        struct32, featEn, styleBad, appendFcs;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  swstyle_top u_dut (
    .clk(clk), .hardRst(hardRst), .softRst(softRst), .stopIn(stopIn),
    .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .ptrIn(ptrIn), .txBit29(txBit29), .masterAddr(masterAddr), .struct32(struct32),
    .featEn(featEn), .styleBad(styleBad), .featOut(featOut), .appendFcs(appendFcs)
  );

  localparam int NVEC = 7;
  // {code, expFeat, expStruct}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'h01, 1'b0, 1'b1},
    {8'h02, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b0},
    {8'h03, 1'b0, 1'b0},
    {8'h02, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1}
  };

  localparam logic [7:0]  IADR = 8'hA5;
  localparam logic [31:0] PTR  = 32'h1234_5678;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] data);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 data = rdData;
    rdEn = 1'b0;
  endtask

  task automatic pulseReset(input bit hard);
    @(negedge clk);
    if (hard) hardRst = 1'b1; else softRst = 1'b1;
    @(negedge clk);
    hardRst = 1'b0; softRst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic        expBad;
    hardRst = 1'b1; softRst = 1'b0; stopIn = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    regSel = 2'd0; wrData = '0; ptrIn = PTR; txBit29 = 1'b0;
    repeat (3) @(negedge clk);
    hardRst = 1'b0;

    // R4 reset state
    check("R4 struct32", struct32, 0);
    check("R4 featEn", featEn, 1);
    check("R4 styleBad", styleBad, 0);
    regRead(2'd0, rv); check("R4 style read", rv, 16'h0000);
    regRead(2'd2, rv); check("R4 companion", rv, 16'h0000);
    regRead(2'd3, rv); check("R4 iadr", rv, 16'h0000);
    check("R11 idle rdData", rdData, 0);

    regWrite(2'd3, 16'hFF00 | IADR);
    regRead(2'd3, rv); check("R11 iadr read", rv, {8'h00, IADR});

    expBad = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] code;
      logic ef, es;
      {code, ef, es} = VEC[i];
      if (code > 8'h02) expBad = 1'b1;
      regWrite(2'd0, {8'hC0, code});
      check("R1 R2 featEn", featEn, ef);
      check("R1 R2 struct32", struct32, es);
      check("R2 styleBad", styleBad, expBad);
      regRead(2'd0, rv);
      check("R6 style read", rv, {expBad, 6'b0, es, code});
      check("R7 masterAddr", masterAddr, es ? PTR : {IADR, PTR[23:0]});
      for (int b = 0; b < 2; b++) begin
        @(negedge clk); txBit29 = b[0];
        #1 check("R9 appendFcs", appendFcs, (es && !ef) ? !b[0] : b[0]);
      end
    end

    // R2 sticky through soft reset, then R5 keeps struct32 (style 01)
    pulseReset(1'b0);
    check("R5 featEn", featEn, 1);
    check("R5 struct32 kept", struct32, 1);
    check("R2 bad after soft", styleBad, 1);
    regRead(2'd0, rv); check("R5 style read", rv, 16'h8100);
    check("R9 after soft", appendFcs, txBit29);

    // R3 stop gating
    stopIn = 1'b0;
    regWrite(2'd0, 16'h0001);
    check("R3 ignored write featEn", featEn, 1);
    regRead(2'd0, rv); check("R3 style read gated", rv, 0);
    regRead(2'd1, rv); check("R3 id read gated", rv, 0);
    stopIn = 1'b1;
    regRead(2'd0, rv); check("R3 code unchanged", rv, 16'h8100);

    // R10 identification register
    regWrite(2'd1, 16'hBEEF);
    regRead(2'd1, rv); check("R10 id", rv, 16'h0105);

    // R8 masking
    regWrite(2'd0, 16'h0001);
    regWrite(2'd2, 16'hFFFF);
    check("R8 masked", featOut, 16'hFCCC);
    regRead(2'd2, rv); check("R8 readback", rv, 16'hFFFF);
    regWrite(2'd0, 16'h0002);
    check("R8 unmasked", featOut, 16'hFFFF);

    // R4 hard reset clears sticky and companion
    pulseReset(1'b1);
    check("R4 bad cleared", styleBad, 0);
    check("R4 struct32 cleared", struct32, 0);
    check("R4 featOut", featOut, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule